// File: doc/BRIEF.md
# I2C Target Port for a 24-bit Register Bank

This block is an I2C target that exposes a small bank of 24-bit registers to an external bus controller. SCL and SDA arrive as raw pins. The block oversamples them with the system clock. It pulls SDA low through an output enable, so the pad has an open-drain driver and a pull-up. An internal register pointer selects the register to access. The controller sets the pointer with the first byte of a write. Each register moves as three bytes, most significant byte first. A bus STOP advances the pointer by one, so a later read that carries no address continues at the following register.

Supported transfers:
- Single-register writes.
- Multi-register sequential writes.
- Current-address reads.
- Random reads: an address-only write followed by a repeated START.

On-chip logic sees the same bank through a plain host port. It writes in one cycle and reads combinationally. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure. When the host port and the bus commit to the same register in the same cycle, the bus write takes effect.

Top module: `i2c24_regport`

## Requirements
- R1: After a START, the block compares the first 7 bits (MSB first) with parameter DEV_ADDR. On a match it drives ACK (SDA low) during the ninth SCL clock and takes bit 8 as the direction (1 = read). On a mismatch it does not acknowledge and ignores the bus until the next START.
- R2: In a write, the first byte after the acknowledged address byte loads its low log2(REG_COUNT) bits into the register pointer and is acknowledged. Its upper bits are ignored.
- R3: Each following group of three data bytes forms one 24-bit word, with the first byte as bits 23:16 and bits sent MSB first. Every byte is acknowledged, and the word is written to the bank only when its third byte has arrived.
- R4: In the same write, the first complete group goes to the loaded register and each later group to the next register. A trailing group with fewer than three bytes is dropped and leaves the pointer unchanged.
- R5: A STOP increments the pointer by one, saturating at REG_COUNT-1. This happens only if an acknowledged address byte was seen since the previous STOP. A repeated START never moves the pointer.
- R6: A read transfers the register at the pointer as three bytes, bits 23:16 first, each byte MSB first.
- R7: An address-only write, a repeated START and a read together return the register named by the address byte.
- R8: After the controller acknowledges the third byte of a register, the read goes on with the next register. At REG_COUNT-1 the pointer stays put and that register is sent again.
- R9: When the controller answers a read byte with NACK, the block releases SDA and drives nothing until the next START. START and STOP always release SDA.
- R10: The output enable (1 = SDA pulled low) changes only while SCL is low.
- R11: Reset clears all registers and the pointer to zero. A host write (host_we high) stores host_wdata at host_addr on the clock edge. host_rdata always shows the register at host_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| host_we | input | 1 | Host write strobe |
| host_addr | input | log2(REG_COUNT) | Host register index |
| host_wdata | input | 24 | Host write data |
| host_rdata | output | 24 | Register at host_addr |

## Verification
The assertions assume that each SCL phase lasts much longer than the two-flop synchronizer plus the edge detector. They also assume the controller changes SDA only while SCL is low, except to form START and STOP. Under those assumptions, any output-enable change the block makes lands in the same low phase of SCL, and no false START or STOP is seen. The bench drives the bus with a quarter-bit time of eight system clocks and moves SDA only in the low phase. It models the wired-AND line as the controller's level ANDed with the inverse of sda_oe.

// File: rtl/i2c24_pkg.sv
package i2c24_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } i2c24_st_t;

  localparam int WORD_W = 24;
endpackage

// File: rtl/i2c24_sync.sv
module i2c24_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c24_busev.sv
module i2c24_busev (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c24_bank.sv
module i2c24_bank #(
  parameter int REG_COUNT = 8,
  parameter int DW        = 24,
  localparam int AW       = $clog2(REG_COUNT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_waddr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [AW-1:0] bus_raddr,
  output logic [DW-1:0] bus_rdata
);
  logic [DW-1:0] mem [REG_COUNT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_COUNT; i++) mem[i] <= '0;
    end else begin
      if (host_we) mem[host_addr] <= host_wdata;
      if (bus_we)  mem[bus_waddr] <= bus_wdata;
    end
  end

  assign host_rdata = mem[host_addr];
  assign bus_rdata  = mem[bus_raddr];
endmodule

// File: rtl/i2c24_regport.sv
module i2c24_regport
  import i2c24_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h2A,
  parameter int         REG_COUNT = 8,
  localparam int        AW        = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata
);
  localparam logic [AW-1:0] PTR_MAX = AW'(REG_COUNT - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  i2c24_st_t         st;
  logic [3:0]        bitcnt;
  logic [7:0]        rxsh;
  logic              rw, touched, first_byte, wgrp_done, mack;
  logic [15:0]       wbuf;
  logic [1:0]        wbyte_idx, txbyte_idx;
  logic [WORD_W-1:0] txsh, bus_rdata;
  logic [AW-1:0]     ptr, bank_waddr, bank_raddr;
  logic              bank_we, ld_ptr, rx_done;

  function automatic logic [AW-1:0] sat_inc(input logic [AW-1:0] x);
    return (x == PTR_MAX) ? x : x + 1'b1;
  endfunction

  i2c24_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  i2c24_busev u_ev (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign rx_done    = (st == ST_RX) && scl_fall && (bitcnt == 4'd8);
  assign ld_ptr     = rx_done && first_byte;
  assign bank_we    = rx_done && !first_byte && (wbyte_idx == 2'd2);
  assign bank_waddr = wgrp_done ? sat_inc(ptr) : ptr;
  assign bank_raddr = (st == ST_TXACK && txbyte_idx == 2'd2) ? sat_inc(ptr) : ptr;

  i2c24_bank #(.REG_COUNT(REG_COUNT), .DW(WORD_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .bus_we(bank_we), .bus_waddr(bank_waddr), .bus_wdata({wbuf, rxsh}),
    .bus_raddr(bank_raddr), .bus_rdata(bus_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;       bitcnt <= '0;     rxsh <= '0;
      rw <= 1'b0;          touched <= 1'b0;  first_byte <= 1'b0;
      wgrp_done <= 1'b0;   mack <= 1'b0;     wbuf <= '0;
      wbyte_idx <= '0;     txbyte_idx <= '0; txsh <= '0;
      ptr <= '0;           sda_oe <= 1'b0;
    end else if (start_ev) begin
      st <= ST_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      st <= ST_IDLE;
      sda_oe <= 1'b0;
      if (touched) begin
        ptr <= sat_inc(ptr);
        touched <= 1'b0;
      end
    end else begin
      case (st)
        ST_ADDR: begin
          if (scl_rise) begin
            rxsh <= {rxsh[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (rxsh[7:1] == DEV_ADDR) begin
              sda_oe <= 1'b1;
              rw <= rxsh[0];
              touched <= 1'b1;
              st <= ST_AACK;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          bitcnt <= '0;
          if (rw) begin
            txsh <= bus_rdata;
            sda_oe <= ~bus_rdata[WORD_W-1];
            txbyte_idx <= '0;
            st <= ST_TX;
          end else begin
            sda_oe <= 1'b0;
            first_byte <= 1'b1;
            wbyte_idx <= '0;
            wgrp_done <= 1'b0;
            st <= ST_RX;
          end
        end
        ST_RX: begin
          if (scl_rise) begin
            rxsh <= {rxsh[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (rx_done) begin
            sda_oe <= 1'b1;
            st <= ST_RXACK;
            if (first_byte) begin
              ptr <= rxsh[AW-1:0];
              first_byte <= 1'b0;
            end else if (wbyte_idx == 2'd2) begin
              ptr <= bank_waddr;
              wgrp_done <= 1'b1;
              wbyte_idx <= '0;
            end else begin
              wbuf <= {wbuf[7:0], rxsh};
              wbyte_idx <= wbyte_idx + 1'b1;
            end
          end
        end
        ST_RXACK: if (scl_fall) begin
          sda_oe <= 1'b0;
          bitcnt <= '0;
          st <= ST_RX;
        end
        ST_TX: if (scl_fall) begin
          txsh <= txsh << 1;
          if (bitcnt == 4'd7) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            st <= ST_TXACK;
          end else begin
            sda_oe <= ~txsh[WORD_W-2];
            bitcnt <= bitcnt + 1'b1;
          end
        end
        ST_TXACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              st <= ST_TX;
              if (txbyte_idx == 2'd2) begin
                ptr <= bank_raddr;
                txsh <= bus_rdata;
                sda_oe <= ~bus_rdata[WORD_W-1];
                txbyte_idx <= '0;
              end else begin
                sda_oe <= ~txsh[WORD_W-1];
                txbyte_idx <= txbyte_idx + 1'b1;
              end
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c24_regport_chk.sv
module i2c24_regport_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          start_ev,
  input logic          stop_ev,
  input logic          bank_we,
  input logic [AW-1:0] bank_waddr,
  input logic [AW-1:0] ptr,
  input logic          ld_ptr
);
  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R9
  release_on_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev || stop_ev) |=> !sda_oe);

  // R4
  write_ptr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |=> (ptr == $past(bank_waddr)));

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> ($past(ld_ptr) || ptr == AW'($past(ptr) + 1'b1)));
endmodule

bind i2c24_regport i2c24_regport_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_ev(start_ev), .stop_ev(stop_ev), .bank_we(bank_we),
  .bank_waddr(bank_waddr), .ptr(ptr), .ld_ptr(ld_ptr)
);

// File: tb/test_i2c24_regport.sv
module test_i2c24_regport;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, host_we = 1'b0;
  logic [2:0] host_addr = '0;
  logic [23:0] host_wdata = '0, host_rdata;
  wire sda_bus = m_sda & ~sda_oe;

  int checks = 0, errs = 0, oe_viol = 0;
  bit finished = 0;
  logic oe_q = 1'b0;

  always #10 clk = ~clk;

  i2c24_regport i_i2c24_regport (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_q && m_scl) oe_viol++;
    oe_q = sda_oe;
  end

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic b_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic b_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic b_wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
    end
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); ack = ~sda_bus; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic b_rbyte(input logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); m_scl = 1'b1; wq(); b[i] = sda_bus; wq(); m_scl = 1'b0;
    end
    m_sda = ~give_ack; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
    m_sda = 1'b1;
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [23:0] d);
    @(negedge clk); host_addr = a; @(negedge clk); d = host_rdata;
  endtask

  task automatic rd_bytes(input int n, output logic [47:0] d);
    logic [7:0] b;
    d = '0;
    for (int i = 0; i < n; i++) begin
      b_rbyte(i != n - 1, b);
      d = {d[39:0], b};
    end
  endtask

  task automatic t_reset();
    logic [23:0] d;
    chk("R11 reset oe", {47'd0, sda_oe}, 48'd0);
    host_rd(3'd4, d);
    chk("R11 reset reg", {24'd0, d}, 48'd0);
  endtask

  task automatic t_host();
    logic [23:0] d;
    host_wr(3'd0, 24'h112233); host_wr(3'd3, 24'h0A0B0C);
    host_wr(3'd5, 24'hABCDEF); host_wr(3'd6, 24'h665544);
    host_wr(3'd7, 24'h778899);
    host_rd(3'd5, d);
    chk("R11 host write/read", {24'd0, d}, {24'd0, 24'hABCDEF});
  endtask

  task automatic t_bad_addr();
    logic a;
    b_start(); b_wbyte({7'h15, 1'b0}, a);
    chk("R1 mismatch no ack", {47'd0, a}, 48'd0);
    b_wbyte(8'h03, a);
    chk("R1 ignored until START", {47'd0, a}, 48'd0);
    b_stop();
  endtask

  task automatic t_cur_read(input string req, input logic [23:0] exp);
    logic a; logic [47:0] d;
    b_start(); b_wbyte({DEV, 1'b1}, a);
    chk({req, " R1 read addr ack"}, {47'd0, a}, 48'd1);
    rd_bytes(3, d); b_stop();
    chk({req, " R6 current read"}, d, {24'd0, exp});
  endtask

  task automatic t_write(input logic [7:0] ra, input int nbytes, input logic [47:0] data);
    logic a, all_ack;
    all_ack = 1'b1;
    b_start(); b_wbyte({DEV, 1'b0}, a);
    chk("R1 write addr ack", {47'd0, a}, 48'd1);
    b_wbyte(ra, a);
    chk("R2 reg addr ack", {47'd0, a}, 48'd1);
    for (int i = 0; i < nbytes; i++) begin
      b_wbyte(data[47 - 8*i -: 8], a);
      all_ack &= a;
    end
    b_stop();
    chk("R3 data bytes acked", {47'd0, all_ack}, 48'd1);
  endtask

  task automatic t_rand_read(input logic [7:0] ra, input int nbytes, input logic [47:0] exp, input string req);
    logic a; logic [47:0] d;
    b_start(); b_wbyte({DEV, 1'b0}, a); b_wbyte(ra, a);
    b_start(); b_wbyte({DEV, 1'b1}, a);
    rd_bytes(nbytes, d); b_stop();
    chk(req, d, exp);
  endtask

  task automatic t_nack();
    logic a; logic [7:0] b; int drv;
    drv = 0;
    b_start(); b_wbyte({DEV, 1'b0}, a); b_wbyte(8'h00, a);
    b_start(); b_wbyte({DEV, 1'b1}, a);
    b_rbyte(1'b0, b);
    chk("R9 first byte before NACK", {40'd0, b}, 48'h11);
    for (int i = 0; i < 9; i++) begin
      wq(); m_scl = 1'b1; if (sda_oe) drv++; wq(); if (sda_oe) drv++;
      wq(); m_scl = 1'b0; wq(); if (sda_oe) drv++;
    end
    b_stop();
    chk("R9 silent after NACK", 48'(drv), 48'd0);
  endtask

  initial begin
    logic [23:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_host();
    t_bad_addr();
    t_cur_read("R5 no step after unacked", 24'h112233);
    t_write(8'hF2, 3, {24'h123456, 24'd0});
    host_rd(3'd2, d);
    chk("R2 R3 single write", {24'd0, d}, {24'd0, 24'h123456});
    t_cur_read("R5 STOP step", 24'h0A0B0C);
    t_write(8'h04, 8, {24'hC0FFEE, 24'h5A5A01});
    host_rd(3'd4, d);
    chk("R4 first group", {24'd0, d}, {24'd0, 24'hC0FFEE});
    host_rd(3'd5, d);
    chk("R4 second group", {24'd0, d}, {24'd0, 24'h5A5A01});
    host_rd(3'd6, d);
    chk("R4 partial dropped", {24'd0, d}, {24'd0, 24'h665544});
    t_cur_read("R4 R5 pointer after groups", 24'h665544);
    t_rand_read(8'h04, 6, {24'hC0FFEE, 24'h5A5A01}, "R7 R8 random read two regs");
    t_cur_read("R5 after read", 24'h665544);
    t_rand_read(8'h07, 6, {24'h778899, 24'h778899}, "R8 saturate at top");
    t_cur_read("R5 saturated step", 24'h778899);
    t_nack();
    chk("R10 oe stable while SCL high", 48'(oe_viol), 48'd0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errs++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule